// File: doc/BRIEF.md
# General-Purpose Strobe Port Controller

This block lets a host on an ISA-style I/O bus use one spare pin as a strobe. The strobe can clock an external byte latch, which then acts as an extra output port, or it can enable an external tristate buffer, which then acts as an extra input port. The host reaches the block through an index/data port pair. It first writes a register number to the index port and then accesses that register through the data port. Two registers are held here:

- a control register, whose mode field picks the strobe function and whose drive bit picks the pin drive style;
- a shadow copy of the byte last sent to the external latch.

The strobe is built combinationally from the held mode, the held index and the live host I/O pulse, so it tracks the pulse with no clock delay. All register state changes on the first clock edge after the host write pulse ends, using the bus values sampled while the pulse was low. A low power-good input clears everything. The external latch is wired to the same power-good signal, so the latch and the shadow both come out of reset at zero.

The block has no streaming interface: every pin is a plain level-sensitive control or data signal, and there is no back-pressure.

Top module: `gpstb_port_ctrl`

## Requirements
- R1: The control register sits at index 0x0B. Its mode field occupies bits 4:3 with these encodings: 2'b10 selects write-strobe, 2'b01 selects read-strobe, and 2'b00 and 2'b11 leave the strobe idle.
- R2: In write-strobe mode, a data-port write while the held index is 0x0A drives `strb_o` low during exactly the cycles in which `iow_n` is low.
- R3: In read-strobe mode, a data-port read while the held index is 0x0A drives `strb_o` low during exactly the cycles in which `ior_n` is low.
- R4: Every data-port write to index 0x0A stores `sd_in[15:8]` into the shadow register, in any mode. The stored value is the bus value sampled on the last clock while `iow_n` was low, and it takes effect on the first clock after `iow_n` rises.
- R5: A data-port read of index 0x0A outside read-strobe mode drives the shadow byte on `rd_data[15:8]` with `rd_oe_hi` set. In read-strobe mode `rd_oe_hi` stays low, so the external buffer owns the upper byte.
- R6: Control bit 2 selects totem-pole drive, in which `strb_oe` is always 1. When bit 2 is clear the drive is open-drain, and `strb_oe` is 1 only while `strb_o` is low.
- R7: While `pwrgood` is low, the index, control and shadow registers are cleared to zero and the strobe is released.
- R8: An index-port write (`addr_sel`=0) loads `sd_in[7:0]` into the index register. An index-port read returns the index on `rd_data[7:0]` with `rd_oe_lo` set. Decoding always uses the held index.
- R9: A data-port read of index 0x0B returns the control bits 4:2 in place on `rd_data[7:0]`, with all other bits reading zero.
- R10: Accesses to any index other than 0x0A never pull `strb_o` low, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to commit register writes |
| pwrgood | input | 1 | Power-good; low clears all state (asynchronous) |
| addr_sel | input | 1 | 0 = index port, 1 = data port |
| iow_n | input | 1 | Host I/O write pulse, active low |
| ior_n | input | 1 | Host I/O read pulse, active low |
| sd_in | input | 16 | Host data bus as seen by the block |
| rd_data | output | 16 | Read data returned to the host |
| rd_oe_lo | output | 1 | Block drives `rd_data[7:0]` onto the bus |
| rd_oe_hi | output | 1 | Block drives `rd_data[15:8]` onto the bus |
| strb_o | output | 1 | Strobe pin level (low = active) |
| strb_oe | output | 1 | Strobe pin output enable |

## Verification
On every cycle the assertions check four things:

- the drive-style rule, which ties `strb_oe` to the control bit and the strobe level;
- that the strobe is never active without a host pulse;
- that the shadow and control registers hold their values except on a commit;
- that the upper read lane is driven only during a read outside read-strobe mode.

Only the bench's scenarios can show the other behaviours:

- the pulse-exact strobe timing for each of the four modes;
- that the byte written to the shadow is the one read back;
- that other indexes leave the strobe idle;
- that a power-good drop mid-session clears the shadow so it matches the external latch.

// File: rtl/gps_pkg.sv
package gps_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_RDSTB = 2'b01,
    MODE_WRSTB = 2'b10,
    MODE_IDLE2 = 2'b11
  } strb_mode_e;

  localparam int MODE_LSB  = 3;
  localparam int DRIVE_BIT = 2;
endpackage

// File: rtl/gps_regs.sv
module gps_regs
  import gps_pkg::*;
#(
  parameter int          IDX_W    = 8,
  parameter int          BUS_W    = 16,
  parameter logic [7:0]  DATA_IDX = 8'h0A,
  parameter logic [7:0]  CTRL_IDX = 8'h0B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iow_n,
  input  logic             addr_sel,
  input  logic [BUS_W-1:0] sd_in,
  output logic [IDX_W-1:0] idx_q,
  output strb_mode_e       mode_q,
  output logic             totem_q,
  output logic [BUS_W/2-1:0] shadow_q
);
  localparam int LANE_W = BUS_W / 2;

  logic             iow_prev;
  logic [BUS_W-1:0] hold_data;
  logic             hold_sel;
  logic             commit;

  // A write completes on the first clock that sees iow_n high after low.
  assign commit = !iow_prev && iow_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iow_prev  <= 1'b1;
      hold_data <= '0;
      hold_sel  <= 1'b0;
    end else begin
      iow_prev <= iow_n;
      if (!iow_n) begin
        hold_data <= sd_in;
        hold_sel  <= addr_sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      mode_q   <= MODE_IDLE;
      totem_q  <= 1'b0;
      shadow_q <= '0;
    end else if (commit) begin
      if (!hold_sel) begin
        idx_q <= hold_data[IDX_W-1:0];
      end else if (idx_q == IDX_W'(DATA_IDX)) begin
        shadow_q <= hold_data[BUS_W-1:LANE_W];
      end else if (idx_q == IDX_W'(CTRL_IDX)) begin
        mode_q  <= strb_mode_e'(hold_data[MODE_LSB+1:MODE_LSB]);
        totem_q <= hold_data[DRIVE_BIT];
      end
    end
  end

  p_shadow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(shadow_q));
  p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(mode_q) && $stable(totem_q)));
endmodule

// File: rtl/gps_strobe.sv
module gps_strobe
  import gps_pkg::*;
(
  input  logic       rst_n,
  input  logic       clk,
  input  strb_mode_e mode_q,
  input  logic       totem_q,
  input  logic       data_hit,
  input  logic       iow_n,
  input  logic       ior_n,
  output logic       strb_o,
  output logic       strb_oe
);
  logic wr_fire, rd_fire, active;

  always_comb begin
    wr_fire = (mode_q == MODE_WRSTB) && data_hit && !iow_n;
    rd_fire = (mode_q == MODE_RDSTB) && data_hit && !ior_n;
    active  = wr_fire || rd_fire;
  end

  assign strb_o  = !active;
  assign strb_oe = totem_q || active;

  p_strobe_needs_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_o |-> (data_hit && (!iow_n || !ior_n)));
  p_open_drain_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!totem_q && strb_o) |-> !strb_oe);
  p_totem_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    totem_q |-> strb_oe);
endmodule

// File: rtl/gps_rdmux.sv
module gps_rdmux
  import gps_pkg::*;
#(
  parameter int         IDX_W    = 8,
  parameter int         BUS_W    = 16,
  parameter logic [7:0] DATA_IDX = 8'h0A,
  parameter logic [7:0] CTRL_IDX = 8'h0B
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ior_n,
  input  logic               addr_sel,
  input  logic [IDX_W-1:0]   idx_q,
  input  strb_mode_e         mode_q,
  input  logic               totem_q,
  input  logic [BUS_W/2-1:0] shadow_q,
  output logic [BUS_W-1:0]   rd_data,
  output logic               rd_oe_lo,
  output logic               rd_oe_hi
);
  localparam int LANE_W = BUS_W / 2;

  logic [LANE_W-1:0] ctrl_view;

  always_comb begin
    ctrl_view = '0;
    ctrl_view[MODE_LSB+1:MODE_LSB] = mode_q;
    ctrl_view[DRIVE_BIT]           = totem_q;
  end

  always_comb begin
    rd_data  = '0;
    rd_oe_lo = 1'b0;
    rd_oe_hi = 1'b0;
    if (!ior_n) begin
      if (!addr_sel) begin
        rd_data[LANE_W-1:0] = LANE_W'(idx_q);
        rd_oe_lo = 1'b1;
      end else if (idx_q == IDX_W'(CTRL_IDX)) begin
        rd_data[LANE_W-1:0] = ctrl_view;
        rd_oe_lo = 1'b1;
      end else if (idx_q == IDX_W'(DATA_IDX) && mode_q != MODE_RDSTB) begin
        rd_data[BUS_W-1:LANE_W] = shadow_q;
        rd_oe_hi = 1'b1;
      end
    end
  end

  p_hi_lane_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe_hi |-> (!ior_n && mode_q != MODE_RDSTB && addr_sel));
endmodule

// File: rtl/gpstb_port_ctrl.sv
module gpstb_port_ctrl
  import gps_pkg::*;
#(
  parameter int         IDX_W    = 8,
  parameter int         BUS_W    = 16,
  parameter logic [7:0] DATA_IDX = 8'h0A,
  parameter logic [7:0] CTRL_IDX = 8'h0B
) (
  input  logic             clk,
  input  logic             pwrgood,
  input  logic             addr_sel,
  input  logic             iow_n,
  input  logic             ior_n,
  input  logic [BUS_W-1:0] sd_in,
  output logic [BUS_W-1:0] rd_data,
  output logic             rd_oe_lo,
  output logic             rd_oe_hi,
  output logic             strb_o,
  output logic             strb_oe
);
  localparam int LANE_W = BUS_W / 2;

  logic [IDX_W-1:0]  idx_q;
  strb_mode_e        mode_q;
  logic              totem_q;
  logic [LANE_W-1:0] shadow_q;
  logic              data_hit;

  assign data_hit = addr_sel && (idx_q == IDX_W'(DATA_IDX));

  gps_regs #(.IDX_W(IDX_W), .BUS_W(BUS_W), .DATA_IDX(DATA_IDX), .CTRL_IDX(CTRL_IDX)) u_regs (
    .clk(clk), .rst_n(pwrgood), .iow_n(iow_n), .addr_sel(addr_sel), .sd_in(sd_in),
    .idx_q(idx_q), .mode_q(mode_q), .totem_q(totem_q), .shadow_q(shadow_q)
  );

  gps_strobe u_strobe (
    .rst_n(pwrgood), .clk(clk), .mode_q(mode_q), .totem_q(totem_q), .data_hit(data_hit),
    .iow_n(iow_n), .ior_n(ior_n), .strb_o(strb_o), .strb_oe(strb_oe)
  );

  gps_rdmux #(.IDX_W(IDX_W), .BUS_W(BUS_W), .DATA_IDX(DATA_IDX), .CTRL_IDX(CTRL_IDX)) u_rdmux (
    .clk(clk), .rst_n(pwrgood), .ior_n(ior_n), .addr_sel(addr_sel), .idx_q(idx_q),
    .mode_q(mode_q), .totem_q(totem_q), .shadow_q(shadow_q),
    .rd_data(rd_data), .rd_oe_lo(rd_oe_lo), .rd_oe_hi(rd_oe_hi)
  );

  // R7: with power-good low the strobe pin is released high
  p_reset_idle_r7: assert property (@(posedge clk) !pwrgood |-> strb_o);
endmodule

// File: tb/tb_gpstb_port_ctrl.sv
module tb_gpstb_port_ctrl;
  logic        clk = 1'b0;
  logic        pwrgood = 1'b0;
  logic        addr_sel = 1'b0;
  logic        iow_n = 1'b1;
  logic        ior_n = 1'b1;
  logic [15:0] sd_in = '0;
  logic [15:0] rd_data;
  logic        rd_oe_lo, rd_oe_hi, strb_o, strb_oe;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // sampled read results
  logic [15:0] s_data;
  logic s_oe_lo, s_oe_hi, s_strb, s_oe;

  always #2.5 clk = ~clk;

  gpstb_port_ctrl dut (
    .clk(clk), .pwrgood(pwrgood), .addr_sel(addr_sel), .iow_n(iow_n), .ior_n(ior_n),
    .sd_in(sd_in), .rd_data(rd_data), .rd_oe_lo(rd_oe_lo), .rd_oe_hi(rd_oe_hi),
    .strb_o(strb_o), .strb_oe(strb_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write cycle; captures strobe mid-pulse into s_strb / s_oe
  task automatic bus_wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    addr_sel = sel; sd_in = d; iow_n = 1'b0;
    @(posedge clk); #1;
    s_strb = strb_o; s_oe = strb_oe;
    @(negedge clk);
    iow_n = 1'b1;
    @(posedge clk); @(posedge clk); #1;
  endtask

  task automatic bus_rd(input logic sel, input logic [15:0] ext);
    @(negedge clk);
    addr_sel = sel; sd_in = ext; ior_n = 1'b0;
    @(posedge clk); #1;
    s_data = rd_data; s_oe_lo = rd_oe_lo; s_oe_hi = rd_oe_hi;
    s_strb = strb_o; s_oe = strb_oe;
    @(negedge clk);
    ior_n = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R7: reset state
    chk("R7 strobe idle in reset", strb_o, 1);
    chk("R7 oe off in reset", strb_oe, 0);
    @(negedge clk); pwrgood = 1'b1;
    @(posedge clk); #1;

    bus_rd(1'b0, 16'h0);
    chk("R7 index zero after reset", s_data[7:0], 0);
    chk("R8 index read lane enable", s_oe_lo, 1);

    bus_wr(1'b0, 16'h000A);
    bus_rd(1'b1, 16'h0);
    chk("R7 shadow zero after reset", s_data[15:8], 0);

    for (int m = 0; m < 4; m++) begin
      for (int t = 0; t < 2; t++) begin
        logic [7:0] pat;
        logic wr_low, rd_low;
        pat    = 8'h5A ^ 8'(m * 37 + t * 91);
        wr_low = (m == 2);
        rd_low = (m == 1);

        // R8: index port write and readback
        bus_wr(1'b0, 16'h000B);
        chk("R10 no strobe on index write", s_strb, 1);
        bus_rd(1'b0, 16'h0);
        chk("R8 index readback", s_data[7:0], 8'h0B);

        // R1/R9: control write with junk in unused bits
        bus_wr(1'b1, {8'hFF, 8'hE3 | 8'(m << 3) | 8'(t << 2)});
        chk("R10 no strobe on control write", s_strb, 1);
        bus_rd(1'b1, 16'h0);
        chk("R9 control readback", s_data[7:0], (m << 3) | (t << 2));

        // idle drive style
        chk("R6 idle oe", strb_oe, t);
        chk("R6 idle level", strb_o, 1);

        // data register access
        bus_wr(1'b0, 16'h000A);
        bus_wr(1'b1, {pat, 8'h00});
        chk("R2 write strobe level", s_strb, !wr_low);
        chk("R6 write oe", s_oe, (t == 1) || wr_low);

        bus_rd(1'b1, {~pat, 8'h00});
        chk("R3 read strobe level", s_strb, !rd_low);
        chk("R6 read oe", s_oe, (t == 1) || rd_low);
        chk("R5 hi lane enable", s_oe_hi, !rd_low);
        if (!rd_low) chk("R4 shadow readback", s_data[15:8], pat);

        // R10: another index never strobes
        bus_wr(1'b0, 16'h000C);
        bus_wr(1'b1, {~pat, 8'h00});
        chk("R10 other index write", s_strb, 1);
        bus_rd(1'b1, 16'h0);
        chk("R10 other index read", s_strb, 1);
        chk("R10 other index undriven", s_oe_hi | s_oe_lo, 0);
      end
    end

    // R4: shadow stored in read-strobe mode too; visible after leaving it
    bus_wr(1'b0, 16'h000B);
    bus_wr(1'b1, 16'h0008);
    bus_wr(1'b0, 16'h000A);
    bus_wr(1'b1, 16'h3C00);
    bus_wr(1'b0, 16'h000B);
    bus_wr(1'b1, 16'h0000);
    bus_wr(1'b0, 16'h000A);
    bus_rd(1'b1, 16'h0);
    chk("R4 shadow stored in read mode", s_data[15:8], 8'h3C);

    // R7: power-good drop clears shadow, control and index
    bus_wr(1'b0, 16'h000B);
    bus_wr(1'b1, 16'h0014);
    bus_wr(1'b0, 16'h000A);
    bus_wr(1'b1, 16'hC300);
    @(negedge clk); pwrgood = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R7 strobe released in reset", strb_o, 1);
    @(negedge clk); pwrgood = 1'b1;
    @(posedge clk); #1;
    chk("R7 oe cleared (open-drain)", strb_oe, 0);
    bus_rd(1'b0, 16'h0);
    chk("R7 index cleared", s_data[7:0], 0);
    bus_wr(1'b0, 16'h000A);
    bus_rd(1'b1, 16'h0);
    chk("R7 shadow cleared", s_data[15:8], 0);
    bus_wr(1'b0, 16'h000B);
    bus_rd(1'b1, 16'h0);
    chk("R7 control cleared", s_data[7:0], 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule